// File: doc/BRIEF.md
# FSK Symbol Timing Recovery and Bit Slicer

This block sits behind an FM discriminator and turns its signed baseband samples into decided data bits. Each accepted sample first has a tracked mean removed, so a frequency offset in the receiver does not move the decision threshold. The corrected stream then drives two consumers. One is a symbol-phase counter that samples each symbol near its centre and nudges its phase with an early-late gate. The other is a zero-crossing interval estimator that can pick the symbol rate by itself.

Three symbol rates are supported: 512, 1200 and 2400 baud. The rate can be forced through a two-bit select, or left to the estimator in automatic mode. The number of samples per symbol is the sample rate divided by the baud rate, rounded down. A lock flag tells the downstream framer when the phase has been steady long enough for the bits to be trusted.

Top module: `fsk_timing_slicer`

## Requirements
- R1: `rate_sel_i` codes 0, 1 and 2 force 512, 1200 and 2400 baud, with floor(FS_HZ / baud) samples per symbol. `rate_o` always reports the rate in use, as one of these three codes.
- R2: Select code 3 is automatic mode. `rate_o` is 1 from reset until the first estimate. After that it is the rate whose samples-per-symbol value is nearest the shortest zero-crossing interval seen over each window of 32 intervals, with ties going to the lower code.
- R3: The mean removed before slicing is a first-order tracker whose gain is 2^-DC_SHIFT (1/64 by default), kept with DC_SHIFT extra fraction bits. Bits come out right when a constant offset smaller than the tone amplitude is added to the input.
- R4: A bit is taken from the corrected sample at the symbol centre, which is phase floor(sps/2). The bit is 1 when that sample is above zero and 0 otherwise. `bit_vld_o` is a one-clock pulse two clocks after the centre sample's strobe, and there is exactly one pulse per symbol when no adjustment is made.
- R5: The early-late gate compares the sign-aligned samples one before and one after the centre. When they differ by more than a quarter of the centre magnitude, the symbol is stretched or shrunk by exactly one sample. This happens at most once per symbol, and the gate drives a transition that lands on the centre out of the window.
- R6: `lock_o` rises at the end of the 16th consecutive symbol with no phase adjustment. On an input that is aligned from the start, exactly 16 bit strobes come before it.
- R7: A change of the rate in use clears `lock_o` on the next clock and restarts the symbol phase.
- R8: While `smp_vld_i` is low, no bit strobe is produced and the mean, phase and lock state hold.
- R9: After reset, `bit_o`, `bit_vld_o` and `lock_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_i | input | SAMPLE_W | Signed discriminator sample |
| smp_vld_i | input | 1 | Sample strobe |
| rate_sel_i | input | 2 | 0: 512, 1: 1200, 2: 2400 baud, 3: automatic |
| bit_o | output | 1 | Decided bit |
| bit_vld_o | output | 1 | One-clock strobe for `bit_o` |
| rate_o | output | 2 | Rate code in use |
| lock_o | output | 1 | Symbol phase is settled |

## Verification
The rate-change restart and the lock counter's step can both fall on the same sample. Whichever comes second must not let a stale count re-raise the lock. The bench provokes this by changing `rate_sel_i` right after lock, and by letting the automatic estimator overturn the default rate while a wrong-rate lock may already be held. It judges the outcome from `lock_o` one clock later, then from the bits collected only after the final lock, which must match a contiguous run of the transmitted pattern.

// File: rtl/fsk_slicer_pkg.sv
package fsk_slicer_pkg;

    localparam logic [1:0] RATE_512  = 2'd0;
    localparam logic [1:0] RATE_1200 = 2'd1;
    localparam logic [1:0] RATE_2400 = 2'd2;
    localparam logic [1:0] RATE_AUTO = 2'd3;

    localparam int BAUD_LOW  = 512;
    localparam int BAUD_MID  = 1200;
    localparam int BAUD_HIGH = 2400;
    localparam int NUM_RATES = 3;

    function automatic int unsigned baud_of(input logic [1:0] code);
        case (code)
            RATE_512:  return BAUD_LOW;
            RATE_1200: return BAUD_MID;
            default:   return BAUD_HIGH;
        endcase
    endfunction

    function automatic int unsigned sps_of(input logic [1:0] code, input int unsigned fs);
        return fs / baud_of(code);
    endfunction

    function automatic int unsigned abs_diff(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : (b - a);
    endfunction

    // Rate whose nominal symbol length is nearest the measured interval; ties keep the lower code
    function automatic logic [1:0] nearest_rate(input int unsigned iv, input int unsigned fs);
        logic [1:0]  best;
        int unsigned best_d;
        int unsigned cur_d;
        best   = RATE_512;
        best_d = abs_diff(iv, sps_of(RATE_512, fs));
        for (int i = 1; i < NUM_RATES; i++) begin
            cur_d = abs_diff(iv, sps_of(2'(i), fs));
            if (cur_d < best_d) begin
                best_d = cur_d;
                best   = 2'(i);
            end
        end
        return best;
    endfunction

endpackage

// File: rtl/fsk_dc_tracker.sv
module fsk_dc_tracker #(
    parameter int SAMPLE_W = 12,
    parameter int DC_SHIFT = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] smp_i,
    input  logic                       smp_vld_i,
    output logic signed [SAMPLE_W:0]   corr_o,
    output logic                       corr_vld_o
);
    localparam int ACC_W = SAMPLE_W + DC_SHIFT + 1;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [SAMPLE_W:0] corr;
        logic              vld;
    } dc_state_t;

    dc_state_t q, d;

    logic signed [ACC_W-1:0] acc_s;
    logic signed [ACC_W-1:0] mean_s;
    logic signed [ACC_W-1:0] x_s;
    logic signed [ACC_W-1:0] diff_s;

    always_comb begin
        acc_s  = $signed(q.acc);
        mean_s = acc_s >>> DC_SHIFT;
        x_s    = ACC_W'(smp_i);
        diff_s = x_s - mean_s;
        d      = q;
        d.vld  = 1'b0;
        if (smp_vld_i) begin
            d.acc  = q.acc + diff_s;
            d.corr = diff_s[SAMPLE_W:0];
            d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign corr_o     = $signed(q.corr);
    assign corr_vld_o = q.vld;

    // R8: the mean estimate does not move between samples
    assert_dc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld_i |=> $stable(q.acc));

endmodule

// File: rtl/fsk_rate_estimator.sv
module fsk_rate_estimator
    import fsk_slicer_pkg::*;
#(
    parameter int SAMPLE_W      = 12,
    parameter int FS_HZ         = 24000,
    parameter int EST_CROSSINGS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [SAMPLE_W:0] corr_i,
    input  logic                     corr_vld_i,
    output logic [1:0]               det_rate_o
);
    localparam int CNT_W = $clog2(FS_HZ / BAUD_LOW + 2) + 1;
    localparam int XC_W  = $clog2(EST_CROSSINGS);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             sgn;
        logic             have_sgn;
        logic             have_x;
        logic [CNT_W-1:0] run;
        logic [CNT_W-1:0] min_iv;
        logic [XC_W-1:0]  nx;
        logic [1:0]       rate;
    } est_state_t;

    est_state_t q, d;

    logic             cur_sgn;
    logic [CNT_W-1:0] iv;
    logic [CNT_W-1:0] best_iv;

    always_comb begin
        d       = q;
        iv      = '0;
        best_iv = '0;
        cur_sgn = (corr_i > 0);
        if (corr_vld_i) begin
            d.sgn      = cur_sgn;
            d.have_sgn = 1'b1;
            if (q.have_sgn && (cur_sgn != q.sgn)) begin
                iv       = (q.run == CNT_MAX) ? CNT_MAX : q.run + 1'b1;
                d.run    = '0;
                d.have_x = 1'b1;
                if (q.have_x) begin
                    best_iv = (iv < q.min_iv) ? iv : q.min_iv;
                    if (q.nx == XC_W'(EST_CROSSINGS - 1)) begin
                        d.rate   = nearest_rate(32'(best_iv), FS_HZ);
                        d.nx     = '0;
                        d.min_iv = CNT_MAX;
                    end else begin
                        d.nx     = q.nx + 1'b1;
                        d.min_iv = best_iv;
                    end
                end
            end else if (q.run != CNT_MAX) begin
                d.run = q.run + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.min_iv <= CNT_MAX;
            q.rate   <= RATE_1200;
        end else begin
            q <= d;
        end
    end

    assign det_rate_o = q.rate;

    // R2: the estimate is always one of the three real rates
    assert_est_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        q.rate != RATE_AUTO);

endmodule

// File: rtl/fsk_symbol_timer.sv
module fsk_symbol_timer
    import fsk_slicer_pkg::*;
#(
    parameter int SAMPLE_W  = 12,
    parameter int FS_HZ     = 24000,
    parameter int LOCK_SYMS = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [SAMPLE_W:0] corr_i,
    input  logic                     corr_vld_i,
    input  logic [1:0]               rate_i,
    output logic                     bit_o,
    output logic                     bit_vld_o,
    output logic                     lock_o
);
    localparam int CNT_W = $clog2(FS_HZ / BAUD_LOW + 2) + 1;
    localparam int LC_W  = $clog2(LOCK_SYMS + 1);
    localparam int MW    = SAMPLE_W + 3;

    typedef enum logic [1:0] {ADJ_NONE, ADJ_LATER, ADJ_EARLIER} adj_e;

    typedef struct packed {
        logic [1:0]        rate_prev;
        logic [CNT_W-1:0]  ph;
        logic [SAMPLE_W:0] early;
        logic [SAMPLE_W:0] cen;
        adj_e              adj;
        logic [LC_W-1:0]   lcnt;
        logic              lock;
        logic              bit_v;
        logic              bvld;
    } tim_state_t;

    tim_state_t q, d;

    logic [CNT_W-1:0] sps_w, half_w, end_w;
    logic signed [MW-1:0] cen_m, e_m, l_m, thr_m;

    always_comb begin
        sps_w  = CNT_W'(sps_of(rate_i, FS_HZ));
        half_w = sps_w >> 1;
        case (q.adj)
            ADJ_LATER:   end_w = sps_w;
            ADJ_EARLIER: end_w = sps_w - 2'd2;
            default:     end_w = sps_w - 1'b1;
        endcase
        // align early/late samples to the centre's polarity
        cen_m = MW'($signed(q.cen));
        e_m   = (cen_m < 0) ? -MW'($signed(q.early)) : MW'($signed(q.early));
        l_m   = (cen_m < 0) ? -MW'(corr_i) : MW'(corr_i);
        thr_m = ((cen_m < 0) ? -cen_m : cen_m) >>> 2;

        d           = q;
        d.bvld      = 1'b0;
        d.rate_prev = rate_i;
        if (rate_i != q.rate_prev) begin
            d.ph   = '0;
            d.adj  = ADJ_NONE;
            d.lcnt = '0;
            d.lock = 1'b0;
        end else if (corr_vld_i) begin
            if (q.ph == half_w - 1'b1) d.early = corr_i;
            if (q.ph == half_w) begin
                d.cen   = corr_i;
                d.bit_v = (corr_i > 0);
                d.bvld  = 1'b1;
            end
            if (q.ph == half_w + 1'b1) begin
                if ((l_m - e_m) > thr_m)      d.adj = ADJ_LATER;
                else if ((e_m - l_m) > thr_m) d.adj = ADJ_EARLIER;
                else                          d.adj = ADJ_NONE;
            end
            if (q.ph >= end_w) begin
                d.ph  = '0;
                d.adj = ADJ_NONE;
                if (q.adj != ADJ_NONE) begin
                    d.lcnt = '0;
                end else if (q.lcnt != LC_W'(LOCK_SYMS)) begin
                    d.lcnt = q.lcnt + 1'b1;
                    if (q.lcnt == LC_W'(LOCK_SYMS - 1)) d.lock = 1'b1;
                end
            end else begin
                d.ph = q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q           <= '0;
            q.rate_prev <= RATE_1200;
        end else begin
            q <= d;
        end
    end

    assign bit_o     = q.bit_v;
    assign bit_vld_o = q.bvld;
    assign lock_o    = q.lock;

    // R5: a symbol never runs past one stretched sample
    assert_phase_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_i == q.rate_prev) |-> (q.ph <= sps_w));

    // R7: a rate change drops lock on the following clock
    assert_lock_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_i != q.rate_prev) |=> !q.lock);

    // R4: each bit strobe lasts one clock
    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.bvld |=> !q.bvld);

endmodule

// File: rtl/fsk_timing_slicer.sv
module fsk_timing_slicer
    import fsk_slicer_pkg::*;
#(
    parameter int SAMPLE_W      = 12,
    parameter int FS_HZ         = 24000,
    parameter int DC_SHIFT      = 6,
    parameter int EST_CROSSINGS = 32,
    parameter int LOCK_SYMS     = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic signed [SAMPLE_W-1:0] smp_i,
    input  logic                       smp_vld_i,
    input  logic [1:0]                 rate_sel_i,
    output logic                       bit_o,
    output logic                       bit_vld_o,
    output logic [1:0]                 rate_o,
    output logic                       lock_o
);
    logic signed [SAMPLE_W:0] corr;
    logic                     corr_vld;
    logic [1:0]               det_rate;
    logic [1:0]               rate_eff;

    fsk_dc_tracker #(
        .SAMPLE_W (SAMPLE_W),
        .DC_SHIFT (DC_SHIFT)
    ) u_dc (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_i      (smp_i),
        .smp_vld_i  (smp_vld_i),
        .corr_o     (corr),
        .corr_vld_o (corr_vld)
    );

    fsk_rate_estimator #(
        .SAMPLE_W      (SAMPLE_W),
        .FS_HZ         (FS_HZ),
        .EST_CROSSINGS (EST_CROSSINGS)
    ) u_est (
        .clk        (clk),
        .rst_n      (rst_n),
        .corr_i     (corr),
        .corr_vld_i (corr_vld),
        .det_rate_o (det_rate)
    );

    assign rate_eff = (rate_sel_i == RATE_AUTO) ? det_rate : rate_sel_i;

    fsk_symbol_timer #(
        .SAMPLE_W  (SAMPLE_W),
        .FS_HZ     (FS_HZ),
        .LOCK_SYMS (LOCK_SYMS)
    ) u_tim (
        .clk        (clk),
        .rst_n      (rst_n),
        .corr_i     (corr),
        .corr_vld_i (corr_vld),
        .rate_i     (rate_eff),
        .bit_o      (bit_o),
        .bit_vld_o  (bit_vld_o),
        .lock_o     (lock_o)
    );

    assign rate_o = rate_eff;

    // R1: the reported rate is never the automatic code
    assert_rate_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rate_o != RATE_AUTO);

    // R4: a bit strobe is always two clocks behind a sample strobe
    assert_strobe_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld_o |-> $past(smp_vld_i, 2));

endmodule

// File: tb/fsk_timing_slicer_bench.sv
`timescale 1ns/1ps
module fsk_timing_slicer_bench;
    localparam int FS  = 24000;
    localparam int NB  = 160;
    localparam int AMP = 1000;

    typedef struct packed {
        logic [1:0] sel;
        logic [1:0] tx_rate;
        int         skew;
        int         off;
    } vec_t;

    // sel, transmitted rate, boundary skew in samples, DC offset
    localparam vec_t VECS [6] = '{
        '{2'd1, 2'd1, 0,  0},
        '{2'd0, 2'd0, 7,  200},
        '{2'd2, 2'd2, 3,  -300},
        '{2'd1, 2'd1, 10, 0},
        '{2'd3, 2'd2, 0,  100},
        '{2'd3, 2'd0, 20, -150}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic signed [11:0] smp = '0;
    logic               smp_vld = 1'b0;
    logic [1:0]         sel = 2'd3;
    logic               bit_o, bit_vld_o, lock_o;
    logic [1:0]         rate_o;

    int checks = 0;
    int fails  = 0;
    int strobes, pre_lock, rx_n;
    logic tx_bits [NB];
    logic rx_bits [NB];

    always #4 clk = ~clk;

    fsk_timing_slicer u_fsk_timing_slicer (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_i      (smp),
        .smp_vld_i  (smp_vld),
        .rate_sel_i (sel),
        .bit_o      (bit_o),
        .bit_vld_o  (bit_vld_o),
        .rate_o     (rate_o),
        .lock_o     (lock_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bench_sps(input logic [1:0] r);
        case (r)
            2'd0:    return FS / 512;
            2'd1:    return FS / 1200;
            default: return FS / 2400;
        endcase
    endfunction

    task automatic build_tx();
        logic [15:0] lfsr = 16'hACE1;
        for (int i = 0; i < NB; i++) begin
            if (i < 64) tx_bits[i] = (i % 2 == 0);
            else begin
                tx_bits[i] = lfsr[0];
                lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
            end
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (bit_vld_o) begin
            strobes++;
            if (lock_o) begin
                if (rx_n < NB) begin
                    rx_bits[rx_n] = bit_o;
                    rx_n++;
                end
            end else pre_lock++;
        end
        if (!lock_o) rx_n = 0;
    endtask

    task automatic apply_reset(input logic [1:0] s);
        rst_n = 1'b0; smp_vld = 1'b0; smp = '0; sel = s;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_case(input vec_t v);
        int sps_tx, total, k, val, found, ok;
        logic [1:0] exp_rate;
        string tag;
        apply_reset(v.sel);
        strobes = 0; pre_lock = 0; rx_n = 0;
        sps_tx = bench_sps(v.tx_rate);
        total  = NB * sps_tx - v.skew;
        for (int n = 0; n < total; n++) begin
            k   = (n + v.skew) / sps_tx;
            val = (tx_bits[k] ? AMP : -AMP) + v.off;
            smp = 12'(val);
            smp_vld = 1'b1;
            tick();
            smp_vld = 1'b0;
            tick();
        end
        tick(); tick();
        exp_rate = (v.sel == 2'd3) ? v.tx_rate : v.sel;
        check(rate_o == exp_rate, (v.sel == 2'd3) ? "R2 rate" : "R1 rate", rate_o, exp_rate);
        check(lock_o == 1'b1, "R6 lock", lock_o, 1);
        tag = (v.skew == 10) ? "R5 bits" : ((v.off != 0) ? "R3 bits" : "R4 bits");
        found = 0;
        if (rx_n >= 20) begin
            for (int kk = 0; kk + rx_n <= NB; kk++) begin
                ok = 1;
                for (int j = 0; j < rx_n; j++)
                    if (rx_bits[j] != tx_bits[kk + j]) ok = 0;
                if (ok == 1) found = 1;
            end
        end
        check(found == 1, tag, found, 1);
    endtask

    initial begin
        int s0;
        logic l0, b0;
        build_tx();
        // R9 reset state, R2 default rate in automatic mode
        apply_reset(2'd3);
        check(bit_vld_o == 1'b0, "R9 strobe", bit_vld_o, 0);
        check(lock_o == 1'b0, "R9 lock", lock_o, 0);
        check(bit_o == 1'b0, "R9 bit", bit_o, 0);
        check(rate_o == 2'd1, "R2 default", rate_o, 1);

        for (int i = 0; i < 6; i++) begin
            run_case(VECS[i]);
            if (i == 0) begin
                // aligned 1200-baud input: one strobe per symbol, lock after 16
                check(strobes == NB, "R4 strobe count", strobes, NB);
                check(pre_lock == 16, "R6 strobes before lock", pre_lock, 16);
                // R8: no samples, no strobes, state held
                s0 = strobes; l0 = lock_o; b0 = bit_o;
                repeat (300) tick();
                check(strobes == s0, "R8 strobes", strobes, s0);
                check(lock_o == l0 && bit_o == b0, "R8 hold", {lock_o, bit_o}, {l0, b0});
                // R7: rate change clears lock on the next clock
                sel = 2'd2;
                tick();
                check(lock_o == 1'b0, "R7 lock drop", lock_o, 0);
                check(rate_o == 2'd2, "R1 rate follows select", rate_o, 2);
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule